// File: doc/BRIEF.md
# Serial Bus Status Register with Double-Buffered Data Paths

This block holds the byte-wide status word of a serial bus controller. Five one-cycle event inputs each set their own flag, and each flag holds until the CPU reads the status: in-frame response byte received, arbitration lost, break symbol seen, message sent, and message received. One more flag is shared by receive overrun and transmit underflow. Bit 5 is not stored; it shows the live bus-activity input. A CPU write to the status arms the transmitter for the next message and sets bit 0.

The block contains a two-stage receive path and a two-stage transmit path, so it can find overrun and underflow on its own. A received byte enters a holding stage. It moves to a buffer stage that the CPU pops. A byte that the CPU writes for transmission enters a buffer stage. It moves to a holding stage that the shifter takes from. The interrupt request is the OR of all the stored event flags.

Top module: `sbus_status_flags`

## Requirements
- R1: After reset the status byte is 0x00 while the bus is idle, irq is 0, rxHasData is 0 and the transmit path is empty.
- R2: A one-cycle pulse on ifrEvt, contendEvt, breakEvt, txDoneEvt or rxDoneEvt sets status bit 7, 6, 4, 2 or 1, respectively, from the next cycle on. The bit stays set while no status read occurs.
- R3: Status bit 5 equals busActive in the same cycle. A status read does not change it.
- R4: A status read clears every stored bit (all except bit 5) at the next clock edge. If an event that sets a bit occurs in the same cycle as the read, that bit is set after the edge.
- R5: A status write pulse sets bit 0 (transmitter armed) from the next cycle on, until a status read.
- R6: Received bytes reach rxDataOut in arrival order. A byte that arrives into empty stages shows up with rxHasData two cycles later. cpuRxRead pops the oldest byte, and a pop when rxHasData is 0 has no effect.
- R7: A byte that arrives while both receive stages hold unread data, with no pop in that cycle, sets bit 3 and is dropped. The two stored bytes stay intact.
- R8: Bytes written with txWrite come out on txByteOut in write order, one per txStart. txByteValid is high in the same cycle as the txStart that delivers a byte.
- R9: A txStart while both transmit stages are empty sets bit 3 from the next cycle on, and txByteValid stays 0.
- R10: A txWrite while both transmit stages are full, with no txStart in that cycle, is ignored.
- R11: irq is the OR of status bits 7, 6, 4, 3, 2 and 1. Bits 5 and 0 do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifrEvt | input | 1 | In-frame response byte received pulse |
| contendEvt | input | 1 | Arbitration lost pulse |
| breakEvt | input | 1 | Break symbol detected pulse |
| txDoneEvt | input | 1 | Message transmitted pulse |
| rxDoneEvt | input | 1 | Message received pulse |
| busActive | input | 1 | Bus carrying a transmission or reception |
| statusRead | input | 1 | CPU read of the status byte |
| statusWrite | input | 1 | CPU write of the status (arms transmitter) |
| rxByteValid | input | 1 | Received byte strobe |
| rxByteIn | input | DATA_W | Received byte |
| cpuRxRead | input | 1 | CPU pop of the oldest received byte |
| txWrite | input | 1 | CPU load of a byte to transmit |
| txByteIn | input | DATA_W | Byte to transmit |
| txStart | input | 1 | Shifter requests the next byte |
| statusByte | output | 8 | Status word |
| irq | output | 1 | Interrupt request |
| rxHasData | output | 1 | Receive buffer stage holds a byte |
| rxDataOut | output | DATA_W | Oldest received byte |
| txByteValid | output | 1 | A byte is handed to the shifter this cycle |
| txByteOut | output | DATA_W | Byte handed to the shifter |

## Verification
The bench builds the block with DATA_W set to 10 instead of the default 8. Its data values use bits 8 and 9, so a stage that drops or swaps upper bits shows up as a wrong value. It puts both paths into every occupancy state: empty, one stage filled, and both filled. This covers arrival into a full receive path with and without a pop, a start on an empty transmit path, and a write into a full one. It also applies events and reads in the same cycle to check that a set wins over a clear.

// File: rtl/sbus_status_pkg.sv
package sbus_status_pkg;

  localparam int STATUS_W   = 8;
  localparam int BIT_IFR    = 7;
  localparam int BIT_CONT   = 6;
  localparam int BIT_BUSY   = 5;
  localparam int BIT_BRK    = 4;
  localparam int BIT_OVUN   = 3;
  localparam int BIT_MSGTX  = 2;
  localparam int BIT_MSGRX  = 1;
  localparam int BIT_ARMED  = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic rxLoadHold;   // capture arriving byte in receive holding stage
    logic rxShift;      // move receive holding stage into buffer stage
    logic txLoadBuf;    // capture CPU byte in transmit buffer stage
    logic txShift;      // move transmit buffer stage into holding stage
    logic txFromHold;   // shifter takes holding stage (else buffer stage)
  } strobe_t;

endpackage

// File: rtl/sbus_status_ctrl.sv
module sbus_status_ctrl
  import sbus_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ifrEvt,
  input  logic                contendEvt,
  input  logic                breakEvt,
  input  logic                txDoneEvt,
  input  logic                rxDoneEvt,
  input  logic                busActive,
  input  logic                statusRead,
  input  logic                statusWrite,
  input  logic                rxByteValid,
  input  logic                cpuRxRead,
  input  logic                txWrite,
  input  logic                txStart,
  output strobe_t             strobes,
  output logic [STATUS_W-1:0] statusByte,
  output logic                irq,
  output logic                rxHasData,
  output logic                txByteValid
);

  localparam logic [STATUS_W-1:0] IRQ_MASK =
    STATUS_W'((1 << BIT_IFR) | (1 << BIT_CONT) | (1 << BIT_BRK) |
              (1 << BIT_OVUN) | (1 << BIT_MSGTX) | (1 << BIT_MSGRX));

  logic rxHoldV, rxBufV, txHoldV, txBufV;
  logic rxPop, rxBufFree, rxHoldFree, overrun;
  logic takeHold, takeBuf, underflow, txHoldFree, txBufFree;
  logic [STATUS_W-1:0] flagQ, setVec;

  // receive occupancy decisions
  always_comb begin
    rxPop      = cpuRxRead && rxBufV;
    rxBufFree  = !rxBufV || rxPop;
    strobes.rxShift    = rxHoldV && rxBufFree;
    rxHoldFree = !rxHoldV || strobes.rxShift;
    strobes.rxLoadHold = rxByteValid && rxHoldFree;
    overrun    = rxByteValid && !rxHoldFree;
  end

  // transmit occupancy decisions
  always_comb begin
    takeHold   = txStart && txHoldV;
    takeBuf    = txStart && !txHoldV && txBufV;
    underflow  = txStart && !txHoldV && !txBufV;
    txHoldFree = !txHoldV || takeHold;
    strobes.txShift    = txBufV && !takeBuf && txHoldFree;
    txBufFree  = !txBufV || takeBuf || strobes.txShift;
    strobes.txLoadBuf  = txWrite && txBufFree;
    strobes.txFromHold = txHoldV;
    txByteValid = takeHold || takeBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHoldV <= 1'b0;
      rxBufV  <= 1'b0;
      txHoldV <= 1'b0;
      txBufV  <= 1'b0;
    end else begin
      rxHoldV <= (rxHoldV && !strobes.rxShift) || strobes.rxLoadHold;
      rxBufV  <= (rxBufV && !rxPop) || strobes.rxShift;
      txHoldV <= (txHoldV && !takeHold) || strobes.txShift;
      txBufV  <= (txBufV && !takeBuf && !strobes.txShift) || strobes.txLoadBuf;
    end
  end

  // sticky flags: set beats read-clear
  always_comb begin
    setVec            = '0;
    setVec[BIT_IFR]   = ifrEvt;
    setVec[BIT_CONT]  = contendEvt;
    setVec[BIT_BRK]   = breakEvt;
    setVec[BIT_OVUN]  = overrun || underflow;
    setVec[BIT_MSGTX] = txDoneEvt;
    setVec[BIT_MSGRX] = rxDoneEvt;
    setVec[BIT_ARMED] = statusWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (statusRead ? '0 : flagQ) | setVec;
  end

  always_comb begin
    statusByte           = flagQ;
    statusByte[BIT_BUSY] = busActive;
    irq                  = |(flagQ & IRQ_MASK);
    rxHasData            = rxBufV;
  end

endmodule

// File: rtl/sbus_status_data.sv
module sbus_status_data
  import sbus_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] rxByteIn,
  input  logic [DATA_W-1:0] txByteIn,
  output logic [DATA_W-1:0] rxDataOut,
  output logic [DATA_W-1:0] txByteOut
);

  logic [DATA_W-1:0] rxHold, rxBuf, txHold, txBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold <= '0;
      rxBuf  <= '0;
      txHold <= '0;
      txBuf  <= '0;
    end else begin
      if (strobes.rxShift)    rxBuf  <= rxHold;
      if (strobes.rxLoadHold) rxHold <= rxByteIn;
      if (strobes.txShift)    txHold <= txBuf;
      if (strobes.txLoadBuf)  txBuf  <= txByteIn;
    end
  end

  always_comb begin
    rxDataOut = rxBuf;
    txByteOut = strobes.txFromHold ? txHold : txBuf;
  end

endmodule

// File: rtl/sbus_status_flags.sv
module sbus_status_flags
  import sbus_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ifrEvt,
  input  logic              contendEvt,
  input  logic              breakEvt,
  input  logic              txDoneEvt,
  input  logic              rxDoneEvt,
  input  logic              busActive,
  input  logic              statusRead,
  input  logic              statusWrite,
  input  logic              rxByteValid,
  input  logic [DATA_W-1:0] rxByteIn,
  input  logic              cpuRxRead,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txByteIn,
  input  logic              txStart,
  output logic [7:0]        statusByte,
  output logic              irq,
  output logic              rxHasData,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              txByteValid,
  output logic [DATA_W-1:0] txByteOut
);

  strobe_t strobes;

  sbus_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ifrEvt(ifrEvt), .contendEvt(contendEvt), .breakEvt(breakEvt),
    .txDoneEvt(txDoneEvt), .rxDoneEvt(rxDoneEvt), .busActive(busActive),
    .statusRead(statusRead), .statusWrite(statusWrite),
    .rxByteValid(rxByteValid), .cpuRxRead(cpuRxRead),
    .txWrite(txWrite), .txStart(txStart),
    .strobes(strobes), .statusByte(statusByte), .irq(irq),
    .rxHasData(rxHasData), .txByteValid(txByteValid)
  );

  sbus_status_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rxByteIn(rxByteIn), .txByteIn(txByteIn),
    .rxDataOut(rxDataOut), .txByteOut(txByteOut)
  );

endmodule

// File: rtl/sbus_status_checker.sv
module sbus_status_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ifrEvt,
  input logic              breakEvt,
  input logic              busActive,
  input logic              statusRead,
  input logic              statusWrite,
  input logic              rxByteValid,
  input logic              cpuRxRead,
  input logic              txStart,
  input logic [7:0]        statusByte,
  input logic              irq,
  input logic              rxHasData,
  input logic [DATA_W-1:0] rxDataOut,
  input logic              txByteValid
);

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    ifrEvt |=> statusByte[7]);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[4] && !statusRead) |=> statusByte[4]);

  assert_break_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    breakEvt |=> statusByte[4]);

  assert_busy_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[5] == busActive);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !ifrEvt) |=> !statusByte[7]);

  assert_armed_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusWrite |=> statusByte[0]);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxHasData && !cpuRxRead) |=> (rxHasData && $stable(rxDataOut)));

  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxHasData && rxByteValid && !cpuRxRead) |=> rxHasData);

  assert_underflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && !txByteValid) |=> statusByte[3]);

  assert_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq == (statusByte[7] | statusByte[6] | statusByte[4] |
            statusByte[3] | statusByte[2] | statusByte[1]));

endmodule

bind sbus_status_flags sbus_status_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ifrEvt(ifrEvt), .breakEvt(breakEvt),
  .busActive(busActive), .statusRead(statusRead), .statusWrite(statusWrite),
  .rxByteValid(rxByteValid), .cpuRxRead(cpuRxRead), .txStart(txStart),
  .statusByte(statusByte), .irq(irq), .rxHasData(rxHasData),
  .rxDataOut(rxDataOut), .txByteValid(txByteValid)
);

// File: tb/sim_sbus_status_flags.sv
module sim_sbus_status_flags;

  localparam int DW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ifrEvt = 0, contendEvt = 0, breakEvt = 0, txDoneEvt = 0, rxDoneEvt = 0;
  logic busActive = 0, statusRead = 0, statusWrite = 0;
  logic rxByteValid = 0, cpuRxRead = 0, txWrite = 0, txStart = 0;
  logic [DW-1:0] rxByteIn = '0, txByteIn = '0;
  logic [7:0] statusByte;
  logic irq, rxHasData, txByteValid;
  logic [DW-1:0] rxDataOut, txByteOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sbus_status_flags #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .ifrEvt(ifrEvt), .contendEvt(contendEvt),
    .breakEvt(breakEvt), .txDoneEvt(txDoneEvt), .rxDoneEvt(rxDoneEvt),
    .busActive(busActive), .statusRead(statusRead), .statusWrite(statusWrite),
    .rxByteValid(rxByteValid), .rxByteIn(rxByteIn), .cpuRxRead(cpuRxRead),
    .txWrite(txWrite), .txByteIn(txByteIn), .txStart(txStart),
    .statusByte(statusByte), .irq(irq), .rxHasData(rxHasData),
    .rxDataOut(rxDataOut), .txByteValid(txByteValid), .txByteOut(txByteOut)
  );

  // advance one clock; inputs change and outputs are sampled 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    statusRead = 1; tick(); statusRead = 0;
  endtask

  task automatic testReset();
    chk("R1 status", statusByte, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 rxHasData", rxHasData, 0);
    txStart = 1; #1;
    chk("R1 tx empty", txByteValid, 0);
    tick(); txStart = 0;
    clearAll();
  endtask

  task automatic testEvents();
    ifrEvt = 1; contendEvt = 1; tick(); ifrEvt = 0; contendEvt = 0;
    chk("R2 ifr+contend", statusByte, 8'hC0);
    chk("R11 irq", irq, 1);
    breakEvt = 1; txDoneEvt = 1; rxDoneEvt = 1; tick();
    breakEvt = 0; txDoneEvt = 0; rxDoneEvt = 0;
    tick(); tick();
    chk("R2 sticky all", statusByte, 8'hD6);
    clearAll();
    chk("R4 cleared", statusByte, 8'h00);
    chk("R4 irq cleared", irq, 0);
  endtask

  task automatic testBusy();
    busActive = 1; #1;
    chk("R3 busy live", statusByte, 8'h20);
    chk("R11 busy no irq", irq, 0);
    statusRead = 1; tick(); statusRead = 0;
    chk("R3 busy survives read", statusByte, 8'h20);
    busActive = 0; #1;
    chk("R3 idle", statusByte, 8'h00);
  endtask

  task automatic testSetWins();
    breakEvt = 1; tick(); breakEvt = 0;
    statusRead = 1; ifrEvt = 1; tick(); statusRead = 0; ifrEvt = 0;
    chk("R4 set beats read", statusByte, 8'h80);
    clearAll();
  endtask

  task automatic testArm();
    statusWrite = 1; tick(); statusWrite = 0;
    chk("R5 armed", statusByte, 8'h01);
    chk("R11 armed no irq", irq, 0);
    tick();
    chk("R5 armed holds", statusByte[0], 1);
    clearAll();
    chk("R5 read clears arm", statusByte, 8'h00);
  endtask

  task automatic testRxOrder();
    cpuRxRead = 1; tick(); cpuRxRead = 0;
    chk("R6 pop empty no effect", rxHasData, 0);
    rxByteValid = 1; rxByteIn = 10'h3A1; tick();
    rxByteValid = 0;
    chk("R6 not yet", rxHasData, 0);
    tick();
    chk("R6 valid after two", rxHasData, 1);
    chk("R6 data", rxDataOut, 10'h3A1);
    rxByteValid = 1; rxByteIn = 10'h2B2; tick(); rxByteValid = 0;
    cpuRxRead = 1; tick(); cpuRxRead = 0;
    chk("R6 second byte", rxDataOut, 10'h2B2);
    cpuRxRead = 1; tick(); cpuRxRead = 0;
    chk("R6 drained", rxHasData, 0);
  endtask

  task automatic testOverrun();
    rxByteValid = 1; rxByteIn = 10'h311; tick();
    rxByteIn = 10'h122; tick();
    rxByteIn = 10'h0F3; tick();
    rxByteValid = 0;
    chk("R7 overrun flag", statusByte, 8'h08);
    chk("R11 overrun irq", irq, 1);
    chk("R7 oldest intact", rxDataOut, 10'h311);
    cpuRxRead = 1; tick(); cpuRxRead = 0;
    chk("R7 second intact", rxDataOut, 10'h122);
    cpuRxRead = 1; tick(); cpuRxRead = 0;
    chk("R7 third dropped", rxHasData, 0);
    clearAll();
    // full path with a pop in the same cycle: no overrun
    rxByteValid = 1; rxByteIn = 10'h201; tick();
    rxByteIn = 10'h202; tick();
    rxByteIn = 10'h203; cpuRxRead = 1; tick();
    rxByteValid = 0; cpuRxRead = 0;
    chk("R7 pop avoids overrun", statusByte, 8'h00);
    chk("R7 next byte", rxDataOut, 10'h202);
    cpuRxRead = 1; tick(); tick(); cpuRxRead = 0;
    chk("R6 drained after pop", rxHasData, 0);
  endtask

  task automatic testTx();
    txWrite = 1; txByteIn = 10'h301; tick();
    txByteIn = 10'h102; tick();
    txByteIn = 10'h203; tick();
    txWrite = 0;
    txStart = 1; #1;
    chk("R8 first valid", txByteValid, 1);
    chk("R8 first byte", txByteOut, 10'h301);
    tick(); #1;
    chk("R8 second byte", txByteOut, 10'h102);
    tick(); #1;
    chk("R10 full write dropped", txByteValid, 0);
    tick(); txStart = 0;
    chk("R9 underflow flag", statusByte, 8'h08);
    clearAll();
    txWrite = 1; txByteIn = 10'h155; tick(); txWrite = 0;
    txStart = 1; #1;
    chk("R8 taken from buffer stage", txByteOut, 10'h155);
    tick(); txStart = 0;
    chk("R9 no underflow", statusByte, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1;
    #1;
    testReset();
    testEvents();
    testBusy();
    testSetWins();
    testArm();
    testRxOrder();
    testOverrun();
    testTx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule